// File: doc/BRIEF.md
# Sequential Integer Power Unit

This block raises an integer base to an integer exponent and returns the power truncated to a fixed output width, so the value is the exact power modulo 2^RES_W. A mode input chooses whether both operands are unsigned or two's-complement signed. In signed mode the unit follows the usual hardware-description-language rules for negative exponents and for the special bases -1, 0 and +1. The one case with no defined value, zero raised to a negative power, is reported on its own flag.

A request is made by pulsing `start` while the unit is idle. Special operand pairs are settled in the cycle that accepts the request. Every other pair runs a square-and-multiply loop, which retires one exponent bit per clock, starting from the least significant bit. `done` pulses once when the answer is ready. The result and the undefined flag then hold their values until a later request completes.

Top module: `int_pow_unit`

## Requirements
- R1: A zero exponent yields 1 for every base, including base 0, in both modes.
- R2: A zero base with a positive exponent yields 0. In signed mode, a zero base with a negative exponent (exponent bit EXP_W-1 set) sets `undef_o` to 1 and `result_o` to 0. Every other request clears `undef_o`.
- R3: A base of 1 yields 1 for every exponent, negative exponents included.
- R4: In signed mode, a base of all ones (-1) yields all ones (-1) when exponent bit 0 is 1 and yields 1 when it is 0, whatever the sign of the exponent.
- R5: In signed mode, a negative exponent with any base other than 0, 1 or -1 yields 0.
- R6: Any other request yields the exact power modulo 2^RES_W, with the base sign-extended in signed mode. Examples: 3^7 = 0x88B, 10^3 = 0x3E8, 2^16 = 0x10000, and 2^n for n >= RES_W is 0.
- R7: In unsigned mode both operands are read as unsigned, so an exponent with its top bit set is a large positive exponent and an all-ones base is 2^BASE_W-1.
- R8: A request covered by R1 to R5 finishes without iterating. `done_o` is high in the cycle after the clock edge that samples `start_i`, and `busy_o` stays low.
- R9: Any other request raises `busy_o` from the accepting edge. `done_o` rises exactly L edges later, where L is the bit length of the exponent. `busy_o` falls at that same edge.
- R10: `done_o` is high for exactly one cycle. `result_o` and `undef_o` keep their values until a later request completes. A `start_i` that arrives while `busy_o` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| signed_mode_i | input | 1 | 1: both operands are two's complement; 0: both unsigned |
| base_i | input | BASE_W | Base operand |
| exp_i | input | EXP_W | Exponent operand |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | RES_W | Power modulo 2^RES_W |
| undef_o | output | 1 | Last result was zero to a negative power |

## Verification
The bench checks every result, flag and latency against a reference. That reference uses plain repeated multiplication, and a small rule table covers negative exponents. A design that tested base 0 before exponent 0 would return 0 for 0^0. A design that treated -1 like any other base with a negative exponent would return 0 instead of the parity answer. A design that sign-extended in unsigned mode would corrupt all-ones bases and large exponents. The bench also counts cycles to done, which exposes a loop that drops or repeats an exponent bit. A second start is issued mid-run and must not disturb the answer, and results are checked to hold over idle cycles.

// File: rtl/pow_pkg.sv
package pow_pkg;
  typedef enum logic [2:0] {
    PC_ITER  = 3'd0,
    PC_ONE   = 3'd1,
    PC_ZERO  = 3'd2,
    PC_MONE  = 3'd3,
    PC_UNDEF = 3'd4
  } pow_case_e;
endpackage

// File: rtl/pow_classify.sv
module pow_classify
  import pow_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int EXP_W  = 8,
  parameter int RES_W  = 32
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              signed_mode_i,
  output pow_case_e         case_o,
  output logic [RES_W-1:0]  spec_res_o,
  output logic              spec_undef_o,
  output logic [RES_W-1:0]  base_ext_o
);
  localparam logic [RES_W-1:0] ONE_R = RES_W'(1);

  logic exp_zero, exp_neg, base_zero, base_one, base_mone;

  // widen base to result width: sign or zero extension
  generate
    if (RES_W > BASE_W) begin : g_ext
      assign base_ext_o = {{(RES_W-BASE_W){signed_mode_i & base_i[BASE_W-1]}}, base_i};
    end else if (RES_W == BASE_W) begin : g_same
      assign base_ext_o = base_i;
    end else begin : g_trunc
      assign base_ext_o = base_i[RES_W-1:0];
    end
  endgenerate

  always_comb begin
    exp_zero  = (exp_i == '0);
    exp_neg   = signed_mode_i & exp_i[EXP_W-1];
    base_zero = (base_i == '0);
    base_one  = (base_i == BASE_W'(1));
    base_mone = signed_mode_i & (&base_i);
    // priority order matters: exponent zero wins over base zero
    if (exp_zero)       case_o = PC_ONE;
    else if (base_zero) case_o = exp_neg ? PC_UNDEF : PC_ZERO;
    else if (base_one)  case_o = PC_ONE;
    else if (base_mone) case_o = PC_MONE;
    else if (exp_neg)   case_o = PC_ZERO;
    else                case_o = PC_ITER;

    spec_undef_o = 1'b0;
    unique case (case_o)
      PC_ONE:   spec_res_o = ONE_R;
      PC_MONE:  spec_res_o = exp_i[0] ? '1 : ONE_R;
      PC_UNDEF: begin spec_res_o = '0; spec_undef_o = 1'b1; end
      default:  spec_res_o = '0;
    endcase
  end
endmodule

// File: rtl/pow_step.sv
module pow_step #(
  parameter int EXP_W = 8,
  parameter int RES_W = 32
) (
  input  logic [RES_W-1:0] acc_i,
  input  logic [RES_W-1:0] sq_i,
  input  logic [EXP_W-1:0] e_i,
  output logic [RES_W-1:0] acc_o,
  output logic [RES_W-1:0] sq_o,
  output logic [EXP_W-1:0] e_o,
  output logic             last_o
);
  logic [RES_W-1:0] prod_acc;
  logic [RES_W-1:0] prod_sq;

  always_comb begin
    prod_acc = acc_i * sq_i;
    prod_sq  = sq_i * sq_i;
    acc_o    = e_i[0] ? prod_acc : acc_i;
    sq_o     = prod_sq;
    e_o      = e_i >> 1;
    last_o   = (e_o == '0);
  end
endmodule

// File: rtl/int_pow_unit.sv
module int_pow_unit
  import pow_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int EXP_W  = 8,
  parameter int RES_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              signed_mode_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o,
  output logic              undef_o
);
  localparam logic [RES_W-1:0] ONE_R = RES_W'(1);

  pow_case_e        cls;
  logic [RES_W-1:0] spec_res, base_ext;
  logic             spec_undef;

  logic             busy_q, busy_d, done_q, done_d, undef_q, undef_d;
  logic [RES_W-1:0] res_q, res_d, acc_q, acc_d, sq_q, sq_d;
  logic [EXP_W-1:0] e_q, e_d;
  logic             op_en, out_en;

  logic [RES_W-1:0] st_acc, st_sq;
  logic [EXP_W-1:0] st_e;
  logic             st_last;

  pow_classify #(.BASE_W(BASE_W), .EXP_W(EXP_W), .RES_W(RES_W)) u_cls (
    .base_i(base_i), .exp_i(exp_i), .signed_mode_i(signed_mode_i),
    .case_o(cls), .spec_res_o(spec_res), .spec_undef_o(spec_undef),
    .base_ext_o(base_ext)
  );

  pow_step #(.EXP_W(EXP_W), .RES_W(RES_W)) u_step (
    .acc_i(acc_q), .sq_i(sq_q), .e_i(e_q),
    .acc_o(st_acc), .sq_o(st_sq), .e_o(st_e), .last_o(st_last)
  );

  // next-state logic
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    undef_d = undef_q;
    res_d  = res_q;
    acc_d  = acc_q;
    sq_d   = sq_q;
    e_d    = e_q;
    op_en  = 1'b0;
    out_en = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        if (cls == PC_ITER) begin
          busy_d = 1'b1;
          acc_d  = ONE_R;
          sq_d   = base_ext;
          e_d    = exp_i;
          op_en  = 1'b1;
        end else begin
          done_d  = 1'b1;
          res_d   = spec_res;
          undef_d = spec_undef;
          out_en  = 1'b1;
        end
      end
    end else begin
      acc_d = st_acc;
      sq_d  = st_sq;
      e_d   = st_e;
      op_en = 1'b1;
      if (st_last) begin
        busy_d  = 1'b0;
        done_d  = 1'b1;
        res_d   = st_acc;
        undef_d = 1'b0;
        out_en  = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      res_q   <= '0;
      acc_q   <= '0;
      sq_q    <= '0;
      e_q     <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (out_en) begin
        res_q   <= res_d;
        undef_q <= undef_d;
      end
      if (op_en) begin
        acc_q <= acc_d;
        sq_q  <= sq_d;
        e_q   <= e_d;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;
  assign undef_o  = undef_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(undef_o)));

  // R1
  zero_exp_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && exp_i == '0) |=> (done_o && result_o == ONE_R && !undef_o && !busy_o));

  // R2
  undef_zero_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (result_o == '0));

  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R9
  busy_done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/tb_int_pow_unit.sv
`timescale 1ns/1ps
module tb_int_pow_unit;
  localparam int BASE_W = 16;
  localparam int EXP_W  = 8;
  localparam int RES_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic              signed_mode_i;
  logic [BASE_W-1:0] base_i;
  logic [EXP_W-1:0]  exp_i;
  logic              busy_o, done_o, undef_o;
  logic [RES_W-1:0]  result_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  int_pow_unit #(.BASE_W(BASE_W), .EXP_W(EXP_W), .RES_W(RES_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_mode_i(signed_mode_i),
    .base_i(base_i), .exp_i(exp_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .undef_o(undef_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // reference: repeated multiplication plus negative-exponent rules
  function automatic logic [RES_W:0] ref_pow(input logic [BASE_W-1:0] b,
                                              input logic [EXP_W-1:0] e,
                                              input logic sm);
    logic [RES_W-1:0] bx, r;
    bx = sm ? RES_W'($signed(b)) : RES_W'(b);
    r  = 1;
    if (sm && e[EXP_W-1]) begin
      if (b == 0)               return {1'b1, {RES_W{1'b0}}};
      else if (b == 1)          r = 1;
      else if (&b)              r = e[0] ? '1 : RES_W'(1);
      else                      r = 0;
    end else begin
      for (int i = 0; i < int'(e); i++) r = r * bx;
    end
    return {1'b0, r};
  endfunction

  function automatic int exp_latency(input logic [BASE_W-1:0] b,
                                     input logic [EXP_W-1:0] e,
                                     input logic sm);
    int bl;
    if (e == 0 || b == 0 || b == 1 || (sm && &b) || (sm && e[EXP_W-1])) return 1;
    bl = 0;
    for (int i = 0; i < EXP_W; i++) if (e[i]) bl = i + 1;
    return 1 + bl;
  endfunction

  task automatic run_op(input logic [BASE_W-1:0] b, input logic [EXP_W-1:0] e,
                        input logic sm, input string tag);
    logic [RES_W:0] ex;
    int cnt, lat;
    ex  = ref_pow(b, e, sm);
    lat = exp_latency(b, e, sm);
    base_i = b; exp_i = e; signed_mode_i = sm; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    cnt = 1;
    while (!done_o && cnt < 40) begin
      @(posedge clk); #1;
      cnt++;
    end
    check({tag, " result"}, 64'(result_o), 64'(ex[RES_W-1:0]));
    check({tag, " undef"},  64'(undef_o),  64'(ex[RES_W]));
    check({tag, " latency R8 R9"}, 64'(cnt), 64'(lat));
    @(posedge clk); #1;
    check({tag, " done one cycle R10"}, 64'(done_o), 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [RES_W-1:0] held;
    int seed;
    rst_n = 1'b0; start_i = 1'b0; signed_mode_i = 1'b0; base_i = '0; exp_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    check("reset busy",   64'(busy_o),   64'd0);
    check("reset done",   64'(done_o),   64'd0);
    check("reset result", 64'(result_o), 64'd0);
    check("reset undef",  64'(undef_o),  64'd0);

    run_op(16'd0, 8'd0, 1'b1, "R1 0^0");
    run_op(16'd7, 8'd0, 1'b0, "R1 7^0");
    run_op(16'hFFFE, 8'd0, 1'b1, "R1 -2^0");
    run_op(16'd0, 8'd3, 1'b0, "R2 0^3");
    run_op(16'd0, 8'hFF, 1'b1, "R2 0^-1 undef");
    run_op(16'd5, 8'd2, 1'b1, "R2 undef cleared");
    run_op(16'd1, 8'hFF, 1'b1, "R3 1^-1");
    run_op(16'd1, 8'd49, 1'b0, "R3 1^49");
    run_op(16'hFFFF, 8'hFF, 1'b1, "R4 -1^-1");
    run_op(16'hFFFF, 8'hFE, 1'b1, "R4 -1^-2");
    run_op(16'hFFFF, 8'd3, 1'b1, "R4 -1^3");
    run_op(16'd2, 8'hFF, 1'b1, "R5 2^-1");
    run_op(16'd3, 8'hFF, 1'b1, "R5 3^-1");
    run_op(16'hFFFE, 8'hFD, 1'b1, "R5 -2^-3");
    run_op(16'd3, 8'd7, 1'b0, "R6 3^7");
    run_op(16'd10, 8'd3, 1'b1, "R6 10^3");
    run_op(16'd2, 8'd16, 1'b0, "R6 2^16");
    run_op(16'd2, 8'd40, 1'b1, "R6 2^40");
    run_op(16'hFFFE, 8'd3, 1'b1, "R6 -2^3");
    run_op(16'hFFFF, 8'd2, 1'b0, "R7 unsigned ffff^2");
    run_op(16'd3, 8'hFF, 1'b0, "R7 unsigned 3^255");
    run_op(16'hFFFF, 8'd0, 1'b0, "R7 unsigned ffff^0");

    // R10: start while busy is ignored
    base_i = 16'd3; exp_i = 8'h7F; signed_mode_i = 1'b1; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(posedge clk); #1;
    base_i = 16'd0; exp_i = 8'd0; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    while (!done_o) begin @(posedge clk); #1; end
    check("R10 start while busy ignored", 64'(result_o), 64'(ref_pow(16'd3, 8'h7F, 1'b1)));
    held = result_o;
    repeat (5) @(posedge clk);
    #1;
    check("R10 result held", 64'(result_o), 64'(held));
    check("R10 busy idle", 64'(busy_o), 64'd0);

    seed = 1234;
    void'($urandom(seed));
    for (int k = 0; k < 400; k++) begin
      logic [BASE_W-1:0] rb;
      logic [EXP_W-1:0]  re;
      logic              rs;
      rb = BASE_W'($urandom);
      re = EXP_W'($urandom);
      rs = 1'($urandom);
      if (k % 4 == 0) rb = BASE_W'($urandom % 4) - BASE_W'(1);
      run_op(rb, re, rs, rs ? "R6 random signed" : "R7 random unsigned");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule